// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This block takes one trap at a time and applies it to the hart's privilege state. A trap request carries a cause word, whose most significant bit flags an interrupt, together with the PC of the trapping instruction and a trap value. On the clock edge that samples the request, the block does four things:

- It picks the destination of the trap: the debug ROM, the supervisor handler or the machine handler.
- It writes that destination's cause, exception PC and trap value registers.
- It pushes the interrupt-enable and privilege stack in the status fields and moves to the new privilege level.
- It issues a redirect PC.

It also produces two pulses. One flushes address translation. The other drops any outstanding load reservation.

The trap vectors, the two delegation masks and the per-privilege breakpoint enables come in as inputs. A small load port lets the surrounding core set the privilege level and the two global interrupt enables. A trap return or a status write would use this port.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset the privilege is machine (code 3; the codes are U=0, S=1, M=3). All status enable and stack bits are 0 and debug mode is inactive. `redirect_valid_o`, `tlb_flush_o`, `resv_clear_o` and `done_o` are all low.
- R2: A trap sampled at a clock edge commits all of its register updates and `redirect_pc_o` at that edge. `redirect_valid_o` is high for the one cycle after that edge, and `done_o` is high for the cycle after that.
- R3: While debug mode is active, a trap whose full cause equals 3 redirects to `DBG_ENTRY`, and any other cause redirects to `DBG_EXC_VEC`. No other state changes, and neither `tlb_flush_o` nor `resv_clear_o` pulses.
- R4: A non-interrupt cause 3 enters debug mode when `ebrk_en_i[priv]` is set, indexed by the current privilege code. Entry records debug cause 1 and the old privilege, copies the trap PC into the debug PC, forces machine privilege and redirects to `DBG_ENTRY`. It leaves every machine and supervisor trap register unchanged.
- R5: The cause index is the cause with its top bit cleared. Interrupts look the index up in `mideleg_i` and exceptions look it up in `medeleg_i`. An index of XLEN or more is never delegated.
- R6: A trap goes to supervisor when the current privilege is U or S and the selected delegation bit is set. The redirect is then `stvec_i`. From machine privilege a trap is never delegated.
- R7: On supervisor entry, SPIE takes the old SIE, SPP takes 1 if the old privilege was S and 0 if it was U, and SIE clears. scause, sepc and stval take the request fields and the privilege becomes S.
- R8: On machine entry the redirect is `mtvec_i` with bit 0 cleared. If `mtvec_i[0]` is 1 and the trap is an interrupt, four times the cause index is added.
- R9: On machine entry, MPIE takes the old MIE, MPP takes the old privilege code and MIE clears. mcause, mepc and mtval take the request fields and the privilege becomes M.
- R10: Every privilege update pulses `tlb_flush_o` in the cycle after the edge. This covers debug entry, supervisor entry, machine entry and the load port. `resv_clear_o` pulses in that cycle only for supervisor and machine entries.
- R11: The load port sets the privilege, MIE and SIE. The reserved privilege code 2 is stored as U. If a trap and a load are sampled at the same edge, the trap is applied and the load is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_valid_i | input | 1 | Trap request |
| trap_cause_i | input | XLEN | Cause word, MSB = interrupt |
| trap_epc_i | input | XLEN | PC of the trapping instruction |
| trap_tval_i | input | XLEN | Trap value |
| mtvec_i | input | XLEN | Machine trap vector, bit 0 = vectored |
| stvec_i | input | XLEN | Supervisor trap vector |
| medeleg_i | input | XLEN | Exception delegation mask |
| mideleg_i | input | XLEN | Interrupt delegation mask |
| ebrk_en_i | input | 4 | Breakpoint-to-debug enable, indexed by privilege code |
| set_valid_i | input | 1 | Load privilege and enables |
| set_priv_i | input | 2 | Privilege to load |
| set_mie_i | input | 1 | MIE to load |
| set_sie_i | input | 1 | SIE to load |
| redirect_valid_o | output | 1 | Redirect pulse |
| redirect_pc_o | output | XLEN | Redirect target |
| tlb_flush_o | output | 1 | Translation flush pulse |
| resv_clear_o | output | 1 | Load reservation invalidate pulse |
| done_o | output | 1 | Trap completion pulse |
| priv_o | output | 2 | Current privilege |
| mie_o | output | 1 | Machine interrupt enable |
| mpie_o | output | 1 | Machine previous enable |
| mpp_o | output | 2 | Machine previous privilege |
| sie_o | output | 1 | Supervisor interrupt enable |
| spie_o | output | 1 | Supervisor previous enable |
| spp_o | output | 1 | Supervisor previous privilege |
| mepc_o | output | XLEN | Machine exception PC |
| mcause_o | output | XLEN | Machine cause |
| mtval_o | output | XLEN | Machine trap value |
| sepc_o | output | XLEN | Supervisor exception PC |
| scause_o | output | XLEN | Supervisor cause |
| stval_o | output | XLEN | Supervisor trap value |
| dbg_active_o | output | 1 | Debug mode active |
| dbg_cause_o | output | 3 | Recorded debug cause |
| dbg_prv_o | output | 2 | Privilege saved on debug entry |
| dpc_o | output | XLEN | Debug PC |

## Verification
A trap request and a load-port write can land on the same edge, and both want to change the privilege and the interrupt enables. The bench drives the two in the same cycle. Before that cycle it loads MIE=1 at machine privilege, and the colliding load asks for U with different enables. It then judges the outcome by priv=M, MPP=M, MIE=0 and MPIE=1, which only the trap-wins rule gives. A second case drives a trap while debug mode is active, where the redirect must happen with no flush and no reservation pulse.

// File: rtl/trap_entry_pkg.sv
// Package: shared encodings for the trap entry controller.
// Assumes privilege codes U=0, S=1, M=3; code 2 is reserved.
package trap_entry_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'b00,
        PRIV_S   = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_M   = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        RT_DBG_REDIR = 2'd0,
        RT_DBG_ENTER = 2'd1,
        RT_SUP       = 2'd2,
        RT_MACH      = 2'd3
    } route_e;

    localparam logic [2:0] DBG_CAUSE_SWBP = 3'd1;

    // Map a requested privilege onto an implemented one.
    function automatic logic [1:0] legal_priv(input logic [1:0] p);
        return (p == PRIV_RSV) ? PRIV_U : p;
    endfunction

endpackage

// File: rtl/trap_route.sv
// Trap routing: combinational choice of trap destination and redirect PC.
// Assumes the cause MSB is the interrupt flag and XLEN is a power of two >= 8.
module trap_route
    import trap_entry_pkg::*;
#(
    parameter int                XLEN        = 32,
    parameter logic [XLEN-1:0]   DBG_ENTRY   = 'h800,
    parameter logic [XLEN-1:0]   DBG_EXC_VEC = 'h808
) (
    input  logic [XLEN-1:0] cause_i,
    input  logic [1:0]      priv_i,
    input  logic            in_debug_i,
    input  logic [3:0]      ebrk_en_i,
    input  logic [XLEN-1:0] medeleg_i,
    input  logic [XLEN-1:0] mideleg_i,
    input  logic [XLEN-1:0] mtvec_i,
    input  logic [XLEN-1:0] stvec_i,
    output route_e          route_o,
    output logic [XLEN-1:0] target_o
);
    localparam int              IDXW  = $clog2(XLEN);
    localparam logic [XLEN-1:0] LIMIT = XLEN'(XLEN);
    localparam logic [XLEN-1:0] BRK   = XLEN'(3);

    logic            is_intr;
    logic [XLEN-1:0] idx;
    logic [XLEN-1:0] deleg_mask;
    logic            deleg_hit;
    logic            is_brk;
    logic [XLEN-1:0] vec_off;

    // Cause decode: interrupt flag, index, delegation lookup.
    always_comb begin
        is_intr    = cause_i[XLEN-1];
        idx        = {1'b0, cause_i[XLEN-2:0]};
        deleg_mask = is_intr ? mideleg_i : medeleg_i;
        deleg_hit  = (idx < LIMIT) && deleg_mask[idx[IDXW-1:0]];
        is_brk     = (cause_i == BRK);
        vec_off    = (mtvec_i[0] && is_intr) ? {idx[XLEN-3:0], 2'b00} : '0;
    end

    // Destination select in priority order: debug, breakpoint, supervisor, machine.
    always_comb begin
        if (in_debug_i) begin
            route_o  = RT_DBG_REDIR;
            target_o = is_brk ? DBG_ENTRY : DBG_EXC_VEC;
        end else if (is_brk && ebrk_en_i[priv_i]) begin
            route_o  = RT_DBG_ENTER;
            target_o = DBG_ENTRY;
        end else if ((priv_i == PRIV_U || priv_i == PRIV_S) && deleg_hit) begin
            route_o  = RT_SUP;
            target_o = stvec_i;
        end else begin
            route_o  = RT_MACH;
            target_o = {mtvec_i[XLEN-1:1], 1'b0} + vec_off;
        end
    end

endmodule

// File: rtl/trap_state.sv
// Trap state: privilege, status stack, trap and debug registers.
// Assumes trap requests take precedence over the load port in one cycle.
module trap_state
    import trap_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_valid_i,
    input  route_e          route_i,
    input  logic [XLEN-1:0] cause_i,
    input  logic [XLEN-1:0] epc_i,
    input  logic [XLEN-1:0] tval_i,
    input  logic            set_valid_i,
    input  logic [1:0]      set_priv_i,
    input  logic            set_mie_i,
    input  logic            set_sie_i,
    output logic [1:0]      priv_o,
    output logic            mie_o,
    output logic            mpie_o,
    output logic [1:0]      mpp_o,
    output logic            sie_o,
    output logic            spie_o,
    output logic            spp_o,
    output logic [XLEN-1:0] mepc_o,
    output logic [XLEN-1:0] mcause_o,
    output logic [XLEN-1:0] mtval_o,
    output logic [XLEN-1:0] sepc_o,
    output logic [XLEN-1:0] scause_o,
    output logic [XLEN-1:0] stval_o,
    output logic            dbg_active_o,
    output logic [2:0]      dbg_cause_o,
    output logic [1:0]      dbg_prv_o,
    output logic [XLEN-1:0] dpc_o
);

    // Register update: reset, then trap by route, else load port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_o       <= PRIV_M;
            mie_o        <= 1'b0;
            mpie_o       <= 1'b0;
            mpp_o        <= 2'b00;
            sie_o        <= 1'b0;
            spie_o       <= 1'b0;
            spp_o        <= 1'b0;
            mepc_o       <= '0;
            mcause_o     <= '0;
            mtval_o      <= '0;
            sepc_o       <= '0;
            scause_o     <= '0;
            stval_o      <= '0;
            dbg_active_o <= 1'b0;
            dbg_cause_o  <= '0;
            dbg_prv_o    <= 2'b00;
            dpc_o        <= '0;
        end else if (trap_valid_i) begin
            case (route_i)
                RT_DBG_ENTER: begin
                    dbg_active_o <= 1'b1;
                    dbg_cause_o  <= DBG_CAUSE_SWBP;
                    dbg_prv_o    <= priv_o;
                    dpc_o        <= epc_i;
                    priv_o       <= PRIV_M;
                end
                RT_SUP: begin
                    spie_o   <= sie_o;
                    spp_o    <= (priv_o == PRIV_S);
                    sie_o    <= 1'b0;
                    scause_o <= cause_i;
                    sepc_o   <= epc_i;
                    stval_o  <= tval_i;
                    priv_o   <= PRIV_S;
                end
                RT_MACH: begin
                    mpie_o   <= mie_o;
                    mpp_o    <= priv_o;
                    mie_o    <= 1'b0;
                    mcause_o <= cause_i;
                    mepc_o   <= epc_i;
                    mtval_o  <= tval_i;
                    priv_o   <= PRIV_M;
                end
                default: begin
                end
            endcase
        end else if (set_valid_i) begin
            priv_o <= legal_priv(set_priv_i);
            mie_o  <= set_mie_i;
            sie_o  <= set_sie_i;
        end
    end

endmodule

// File: rtl/trap_entry_ctrl.sv
// Trap entry controller top: routes one trap per request, updates trap
// state at the sampling edge and emits redirect, flush, reservation-clear
// and done pulses. Assumes vectors and masks are stable while a trap is sampled.
module trap_entry_ctrl
    import trap_entry_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter logic [XLEN-1:0] DBG_ENTRY   = 'h800,
    parameter logic [XLEN-1:0] DBG_EXC_VEC = 'h808
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_valid_i,
    input  logic [XLEN-1:0] trap_cause_i,
    input  logic [XLEN-1:0] trap_epc_i,
    input  logic [XLEN-1:0] trap_tval_i,
    input  logic [XLEN-1:0] mtvec_i,
    input  logic [XLEN-1:0] stvec_i,
    input  logic [XLEN-1:0] medeleg_i,
    input  logic [XLEN-1:0] mideleg_i,
    input  logic [3:0]      ebrk_en_i,
    input  logic            set_valid_i,
    input  logic [1:0]      set_priv_i,
    input  logic            set_mie_i,
    input  logic            set_sie_i,
    output logic            redirect_valid_o,
    output logic [XLEN-1:0] redirect_pc_o,
    output logic            tlb_flush_o,
    output logic            resv_clear_o,
    output logic            done_o,
    output logic [1:0]      priv_o,
    output logic            mie_o,
    output logic            mpie_o,
    output logic [1:0]      mpp_o,
    output logic            sie_o,
    output logic            spie_o,
    output logic            spp_o,
    output logic [XLEN-1:0] mepc_o,
    output logic [XLEN-1:0] mcause_o,
    output logic [XLEN-1:0] mtval_o,
    output logic [XLEN-1:0] sepc_o,
    output logic [XLEN-1:0] scause_o,
    output logic [XLEN-1:0] stval_o,
    output logic            dbg_active_o,
    output logic [2:0]      dbg_cause_o,
    output logic [1:0]      dbg_prv_o,
    output logic [XLEN-1:0] dpc_o
);
    route_e          route;
    logic [XLEN-1:0] target;
    logic            priv_upd;
    logic            resv_upd;

    trap_route #(
        .XLEN        (XLEN),
        .DBG_ENTRY   (DBG_ENTRY),
        .DBG_EXC_VEC (DBG_EXC_VEC)
    ) i_route (
        .cause_i    (trap_cause_i),
        .priv_i     (priv_o),
        .in_debug_i (dbg_active_o),
        .ebrk_en_i  (ebrk_en_i),
        .medeleg_i  (medeleg_i),
        .mideleg_i  (mideleg_i),
        .mtvec_i    (mtvec_i),
        .stvec_i    (stvec_i),
        .route_o    (route),
        .target_o   (target)
    );

    trap_state #(
        .XLEN (XLEN)
    ) i_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .trap_valid_i (trap_valid_i),
        .route_i      (route),
        .cause_i      (trap_cause_i),
        .epc_i        (trap_epc_i),
        .tval_i       (trap_tval_i),
        .set_valid_i  (set_valid_i),
        .set_priv_i   (set_priv_i),
        .set_mie_i    (set_mie_i),
        .set_sie_i    (set_sie_i),
        .priv_o       (priv_o),
        .mie_o        (mie_o),
        .mpie_o       (mpie_o),
        .mpp_o        (mpp_o),
        .sie_o        (sie_o),
        .spie_o       (spie_o),
        .spp_o        (spp_o),
        .mepc_o       (mepc_o),
        .mcause_o     (mcause_o),
        .mtval_o      (mtval_o),
        .sepc_o       (sepc_o),
        .scause_o     (scause_o),
        .stval_o      (stval_o),
        .dbg_active_o (dbg_active_o),
        .dbg_cause_o  (dbg_cause_o),
        .dbg_prv_o    (dbg_prv_o),
        .dpc_o        (dpc_o)
    );

    // Pulse causes: any privilege write flushes; normal entries drop the reservation.
    always_comb begin
        priv_upd = trap_valid_i ? (route != RT_DBG_REDIR) : set_valid_i;
        resv_upd = trap_valid_i && (route == RT_SUP || route == RT_MACH);
    end

    // Output pulses and redirect target, registered at the commit edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid_o <= 1'b0;
            redirect_pc_o    <= '0;
            tlb_flush_o      <= 1'b0;
            resv_clear_o     <= 1'b0;
            done_o           <= 1'b0;
        end else begin
            redirect_valid_o <= trap_valid_i;
            if (trap_valid_i) begin
                redirect_pc_o <= target;
            end
            tlb_flush_o  <= priv_upd;
            resv_clear_o <= resv_upd;
            done_o       <= redirect_valid_o;
        end
    end

endmodule

// File: rtl/trap_entry_chk.sv
// Checker: temporal properties of the trap entry controller, bound to the top.
module trap_entry_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       trap_valid_i,
    input logic       set_valid_i,
    input logic       redirect_valid_o,
    input logic       done_o,
    input logic       tlb_flush_o,
    input logic       resv_clear_o,
    input logic [1:0] priv_o,
    input logic       mie_o,
    input logic       mpie_o,
    input logic       sie_o,
    input logic       spie_o,
    input logic       dbg_active_o
);
    p_redirect_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_i |=> redirect_valid_o);

    p_done_after_r2: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid_o |=> done_o);

    p_debug_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_active_o && trap_valid_i) |=> (!tlb_flush_o && !resv_clear_o && $stable(priv_o)));

    p_debug_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_active_o |=> dbg_active_o);

    p_sup_stack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (resv_clear_o && priv_o == 2'b01) |-> (!sie_o && spie_o == $past(sie_o)));

    p_mach_stack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (resv_clear_o && priv_o == 2'b11) |-> (!mie_o && mpie_o == $past(mie_o)));

    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((trap_valid_i && !dbg_active_o) || set_valid_i) |=> tlb_flush_o);

endmodule

bind trap_entry_ctrl trap_entry_chk i_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .trap_valid_i     (trap_valid_i),
    .set_valid_i      (set_valid_i),
    .redirect_valid_o (redirect_valid_o),
    .done_o           (done_o),
    .tlb_flush_o      (tlb_flush_o),
    .resv_clear_o     (resv_clear_o),
    .priv_o           (priv_o),
    .mie_o            (mie_o),
    .mpie_o           (mpie_o),
    .sie_o            (sie_o),
    .spie_o           (spie_o),
    .dbg_active_o     (dbg_active_o)
);

// File: tb/test_trap_entry_ctrl.sv
// Directed bench for the trap entry controller; one task per scenario.
module test_trap_entry_ctrl;
    localparam int          XLEN  = 32;
    localparam logic [31:0] DENT  = 32'h800;
    localparam logic [31:0] DEXC  = 32'h808;
    localparam logic [31:0] MSB   = 32'h8000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_valid = 1'b0;
    logic [31:0] cause = '0, epc = '0, tval = '0;
    logic [31:0] mtvec = '0, stvec = '0, medeleg = '0, mideleg = '0;
    logic [3:0]  ebrk = '0;
    logic set_valid = 1'b0;
    logic [1:0] set_priv = '0;
    logic set_mie = 1'b0, set_sie = 1'b0;

    logic redirect_valid, tlb_flush, resv_clear, done;
    logic [31:0] redirect_pc;
    logic [1:0] priv, mpp, dbg_prv;
    logic mie, mpie, sie, spie, spp, dbg_active;
    logic [31:0] mepc, mcause, mtval, sepc, scause, stval, dpc;
    logic [2:0] dbg_cause;

    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    trap_entry_ctrl #(.XLEN(XLEN), .DBG_ENTRY(DENT), .DBG_EXC_VEC(DEXC)) i_trap_entry_ctrl (
        .clk(clk), .rst_n(rst_n),
        .trap_valid_i(trap_valid), .trap_cause_i(cause), .trap_epc_i(epc), .trap_tval_i(tval),
        .mtvec_i(mtvec), .stvec_i(stvec), .medeleg_i(medeleg), .mideleg_i(mideleg),
        .ebrk_en_i(ebrk), .set_valid_i(set_valid), .set_priv_i(set_priv),
        .set_mie_i(set_mie), .set_sie_i(set_sie),
        .redirect_valid_o(redirect_valid), .redirect_pc_o(redirect_pc),
        .tlb_flush_o(tlb_flush), .resv_clear_o(resv_clear), .done_o(done),
        .priv_o(priv), .mie_o(mie), .mpie_o(mpie), .mpp_o(mpp),
        .sie_o(sie), .spie_o(spie), .spp_o(spp),
        .mepc_o(mepc), .mcause_o(mcause), .mtval_o(mtval),
        .sepc_o(sepc), .scause_o(scause), .stval_o(stval),
        .dbg_active_o(dbg_active), .dbg_cause_o(dbg_cause), .dbg_prv_o(dbg_prv), .dpc_o(dpc)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load_state(input logic [1:0] p, input logic m, input logic s);
        @(negedge clk);
        set_valid = 1'b1; set_priv = p; set_mie = m; set_sie = s;
        @(negedge clk);
        set_valid = 1'b0;
    endtask

    // Present a trap for one edge; returns at the negedge after the commit edge.
    task automatic fire(input logic [31:0] c, input logic [31:0] e, input logic [31:0] t);
        @(negedge clk);
        trap_valid = 1'b1; cause = c; epc = e; tval = t;
        @(negedge clk);
        trap_valid = 1'b0;
    endtask

    task automatic check_done(input string tag);
        @(negedge clk);
        chk({tag, " done pulse"}, done, 1);
        chk({tag, " redirect one cycle"}, redirect_valid, 0);
    endtask

    task automatic t_reset();
        chk("R1 priv", priv, 3);
        chk("R1 mie", mie, 0);
        chk("R1 sie", sie, 0);
        chk("R1 mpie", mpie, 0);
        chk("R1 dbg", dbg_active, 0);
        chk("R1 pulses", {redirect_valid, tlb_flush, resv_clear, done}, 0);
    endtask

    task automatic t_mach_exc();
        mtvec = 32'h2001; medeleg = '0; mideleg = '0;
        load_state(2'd3, 1'b1, 1'b0);
        chk("R10 load flush", tlb_flush, 1);
        fire(32'd2, 32'h100, 32'hdead);
        chk("R2 redirect valid", redirect_valid, 1);
        chk("R8 exc not vectored", redirect_pc, 32'h2000);
        chk("R9 mcause", mcause, 2);
        chk("R9 mepc", mepc, 32'h100);
        chk("R9 mtval", mtval, 32'hdead);
        chk("R9 mpp", mpp, 3);
        chk("R9 mpie", mpie, 1);
        chk("R9 mie", mie, 0);
        chk("R10 flush", tlb_flush, 1);
        chk("R10 resv", resv_clear, 1);
        check_done("R2");
    endtask

    task automatic t_vec_int();
        mtvec = 32'h1001;
        load_state(2'd3, 1'b1, 1'b0);
        fire(MSB | 32'd7, 32'h104, 32'h0);
        chk("R8 vectored pc", redirect_pc, 32'h101c);
        chk("R9 mcause intr", mcause, MSB | 32'd7);
        chk("R9 priv", priv, 3);
    endtask

    task automatic t_sup_exc();
        medeleg = 32'h100; mideleg = '0; stvec = 32'h3000;
        load_state(2'd0, 1'b0, 1'b1);
        fire(32'd8, 32'h200, 32'h55);
        chk("R6 stvec pc", redirect_pc, 32'h3000);
        chk("R7 priv S", priv, 1);
        chk("R7 scause", scause, 8);
        chk("R7 sepc", sepc, 32'h200);
        chk("R7 stval", stval, 32'h55);
        chk("R7 spp from U", spp, 0);
        chk("R7 spie", spie, 1);
        chk("R7 sie", sie, 0);
        chk("R6 mepc untouched", mepc, 32'h104);
        chk("R10 sup flush+resv", {tlb_flush, resv_clear}, 2'b11);
    endtask

    task automatic t_masks();
        medeleg = '0; mideleg = 32'h20;
        load_state(2'd1, 1'b0, 1'b1);
        fire(MSB | 32'd5, 32'h300, 32'h0);
        chk("R5 intr uses mideleg", priv, 1);
        chk("R7 spp from S", spp, 1);
        chk("R5 scause", scause, MSB | 32'd5);
        load_state(2'd1, 1'b0, 1'b0);
        fire(32'd5, 32'h304, 32'h0);
        chk("R5 exc uses medeleg", priv, 3);
        chk("R9 mpp from S", mpp, 1);
        chk("R8 exc pc", redirect_pc, 32'h1000);
    endtask

    task automatic t_from_m();
        medeleg = '1;
        load_state(2'd3, 1'b0, 1'b0);
        fire(32'd8, 32'h310, 32'h0);
        chk("R6 no deleg from M", priv, 3);
        chk("R6 machine pc", redirect_pc, 32'h1000);
        chk("R6 mcause", mcause, 8);
    endtask

    task automatic t_range();
        medeleg = '1; mideleg = '1;
        load_state(2'd0, 1'b0, 1'b0);
        fire(MSB | 32'd40, 32'h320, 32'h0);
        chk("R5 index >= XLEN to M", priv, 3);
        chk("R8 vector 4*40", redirect_pc, 32'h10a0);
        chk("R9 mpp from U", mpp, 0);
    endtask

    task automatic t_collision();
        medeleg = '0; mideleg = '0;
        load_state(2'd3, 1'b1, 1'b1);
        @(negedge clk);
        trap_valid = 1'b1; cause = 32'd2; epc = 32'h330; tval = 32'h0;
        set_valid = 1'b1; set_priv = 2'd0; set_mie = 1'b1; set_sie = 1'b0;
        @(negedge clk);
        trap_valid = 1'b0; set_valid = 1'b0;
        chk("R11 trap wins priv", priv, 3);
        chk("R11 trap wins mpp", mpp, 3);
        chk("R11 trap wins mie", mie, 0);
        chk("R11 trap wins mpie", mpie, 1);
        chk("R11 trap wins sie", sie, 1);
        load_state(2'd2, 1'b0, 1'b0);
        chk("R11 code 2 stored as U", priv, 0);
    endtask

    task automatic t_brk_off();
        ebrk = 4'b0001;
        load_state(2'd1, 1'b0, 1'b0);
        fire(32'd3, 32'h340, 32'h0);
        chk("R4 disabled priv no debug", dbg_active, 0);
        chk("R4 normal brk mcause", mcause, 3);
    endtask

    task automatic t_dbg_enter();
        ebrk = 4'b0010;
        load_state(2'd1, 1'b0, 1'b0);
        fire(32'd3, 32'h400, 32'h0);
        chk("R4 debug active", dbg_active, 1);
        chk("R4 dbg cause", dbg_cause, 1);
        chk("R4 dbg prv", dbg_prv, 1);
        chk("R4 dpc", dpc, 32'h400);
        chk("R4 priv M", priv, 3);
        chk("R4 pc entry", redirect_pc, DENT);
        chk("R4 mepc untouched", mepc, 32'h340);
        chk("R10 debug entry flush only", {tlb_flush, resv_clear}, 2'b10);
    endtask

    task automatic t_in_dbg();
        fire(32'd3, 32'h500, 32'h0);
        chk("R3 brk to entry", redirect_pc, DENT);
        chk("R3 redirect", redirect_valid, 1);
        chk("R3 no pulses", {tlb_flush, resv_clear}, 0);
        chk("R3 dpc kept", dpc, 32'h400);
        fire(32'd2, 32'h504, 32'h1);
        chk("R3 other to exc vec", redirect_pc, DEXC);
        chk("R3 mcause kept", mcause, 3);
        chk("R3 mepc kept", mepc, 32'h340);
        chk("R3 no pulses 2", {tlb_flush, resv_clear}, 0);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_mach_exc();
        t_vec_int();
        t_sup_exc();
        t_masks();
        t_from_m();
        t_range();
        t_collision();
        t_brk_off();
        t_dbg_enter();
        t_in_dbg();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule